// File: doc/BRIEF.md
# Transmit Descriptor Walker with Status Writeback

This block walks a list of transmit descriptors in memory for a packet DMA engine. Each descriptor is four 32-bit words. The block reads the four words through a single-word memory port that has a request/acknowledge handshake. It then checks that the DMA owns the descriptor, decodes the two buffer byte counts and the linking mode, and sends one fetch command (address plus byte length) per data buffer to a downstream data mover.

For a descriptor that closes a frame, the block waits for the downstream frame-done strobe. If the descriptor asks for it, the block then stores the 64-bit timestamp captured at that strobe over the two address words. Finally it hands the descriptor back to software by clearing the ownership flag in word 0.

When the block meets a descriptor that software still owns, it parks in a suspended state. A poll pulse makes it read that descriptor again. A start pulse, accepted only while idle, begins the walk at a programmed list base. The same base is the wrap target for a ring descriptor flagged as the end of the ring.

Top module: `txdesc_walker`

## Requirements
- R1: After synchronous reset the block is idle: `mem_req`, `cmd_valid` and `suspended` are low, and nothing happens until `start`.
- R2: Word 1 gives the first buffer byte count in bits 12:0 and the second in bits 28:16. Bits 15:13 and 31:29 have no effect on any command.
- R3: A first buffer count of zero issues no command for buffer 1. A command never carries a zero length.
- R4: When word 0 bit 20 is set (chained), no command is issued for buffer 2, whatever its count, and the next descriptor is read from the address held in word 3.
- R5: When word 0 bit 20 is clear (ring), buffer 2 is fetched from the word 3 address with the second count, provided that count is non-zero. The next descriptor is the current address plus 16, or `ring_base` when word 0 bit 21 is set.
- R6: Buffer addresses in words 2 and 3 reach `cmd_addr` unchanged, including unaligned values. Buffer 1 is always commanded before buffer 2.
- R7: When word 0 bit 29 (last segment) is set, the block waits for `frame_done` and samples `ts_in` there. If word 0 bit 25 is also set, the low 32 timestamp bits are written to word 2 and the high 32 bits to word 3. Otherwise words 2 and 3 stay untouched.
- R8: The timestamp writes (word 2, then word 3) come before the release write. The release writes word 0 back as it was read, with bit 31 cleared, and is the last write for that descriptor.
- R9: A word 0 with bit 31 clear makes the block raise `suspended`, issue no command and make no write. A `poll` pulse makes it read that same descriptor again.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_len` hold.
- R11: `start` makes the block read its first descriptor at `ring_base`.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking at `ring_base` (accepted when idle) |
| poll | input | 1 | Re-read the descriptor after a suspend |
| ring_base | input | AW | List base address and ring wrap target |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Buffer fetch command valid |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_addr | output | AW | Buffer start address |
| cmd_len | output | 13 | Buffer length in bytes |
| frame_done | input | 1 | Downstream finished the frame's data |
| ts_in | input | 64 | Timestamp sampled at `frame_done` |
| suspended | output | 1 | Stopped on a descriptor software still owns |

## Verification
A table of single-descriptor cases covers the following: ring with both buffers and a timestamp, ring with an empty first buffer, chained with a non-zero second count that must be dropped, chained with both buffers silent, end-of-ring wrap without the last-segment flag, and the maximum first count with reserved bits set. For each case the bench compares the accepted command list, the address of the next descriptor read, the order of writes and the final memory words against values worked out from the flags. Comparing timestamp-on with timestamp-off cases shows whether words 2 and 3 are overwritten only when both flags are set. Comparing the chained cases with the ring cases shows whether word 3 is used as a link or as a buffer. A directed test then suspends on a software-owned descriptor, hands it over, polls, and holds `cmd_ready` low to confirm the command stays stable and that the walk continues from the right address.

// File: rtl/txd_pkg.sv
package txd_pkg;

    // Word 0 flag positions
    localparam int W0_OWN   = 31;
    localparam int W0_LAST  = 29;
    localparam int W0_TSEN  = 25;
    localparam int W0_EOR   = 21;
    localparam int W0_CHAIN = 20;

    // Word 1 length fields
    localparam int LEN_W   = 13;
    localparam int LEN1_LO = 0;
    localparam int LEN2_LO = 16;

    typedef struct packed {
        logic             owned;
        logic             last_seg;
        logic             ts_en;
        logic             end_ring;
        logic             chained;
        logic [LEN_W-1:0] len1;
        logic [LEN_W-1:0] len2;
    } dctl_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD,
        S_SUSP,
        S_CMD1,
        S_CMD2,
        S_WAIT,
        S_WTSL,
        S_WTSH,
        S_WREL
    } wstate_e;

    function automatic dctl_t unpack_ctl(input logic [31:0] w0,
                                         input logic [LEN_W-1:0] l1,
                                         input logic [LEN_W-1:0] l2);
        dctl_t c;
        c.owned    = w0[W0_OWN];
        c.last_seg = w0[W0_LAST];
        c.ts_en    = w0[W0_TSEN];
        c.end_ring = w0[W0_EOR];
        c.chained  = w0[W0_CHAIN];
        c.len1     = l1;
        c.len2     = l2;
        return c;
    endfunction

endpackage

// File: rtl/txd_decode.sv
module txd_decode
    import txd_pkg::*;
(
    input  logic [31:0] w0,
    input  logic [31:0] w1,
    output dctl_t       ctl,
    output logic        go1,
    output logic        go2
);
    logic [LEN_W-1:0] l1;
    logic [LEN_W-1:0] l2;
    logic             unused_rsv;

    assign l1  = w1[LEN1_LO +: LEN_W];
    assign l2  = w1[LEN2_LO +: LEN_W];
    assign unused_rsv = ^{w1[15:13], w1[31:29]};

    assign ctl = unpack_ctl(w0, l1, l2);
    assign go1 = (l1 != '0);
    assign go2 = !ctl.chained && (l2 != '0);
endmodule

// File: rtl/txd_ptr.sv
module txd_ptr #(
    parameter int AW     = 32,
    parameter int STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          chained,
    input  logic          end_ring,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] STEP = AW'(STRIDE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (advance) begin
            if (chained)       cur <= link;
            else if (end_ring) cur <= base;
            else               cur <= cur + STEP;
        end
    end

    assert_load_base_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(base)));

    assert_chain_link_R4: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && chained) |=> (cur == $past(link)));
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int TSW    = 64,
    parameter int STRIDE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             poll,
    input  logic [AW-1:0]    ring_base,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [AW-1:0]    cmd_addr,
    output logic [LEN_W-1:0] cmd_len,
    input  logic             frame_done,
    input  logic [TSW-1:0]   ts_in,
    output logic             suspended
);
    localparam int HALF = TSW / 2;
    localparam logic [AW-1:0] OFF_W2 = AW'(8);
    localparam logic [AW-1:0] OFF_W3 = AW'(12);

    wstate_e        st;
    logic [1:0]     idx;
    logic [31:0]    w0, w1, w2, w3;
    logic [TSW-1:0] ts_q;
    dctl_t          ctl;
    logic           go1, go2;
    logic [AW-1:0]  cur;
    logic           adv;
    logic           load;

    txd_decode u_dec (
        .w0  (w0),
        .w1  (w1),
        .ctl (ctl),
        .go1 (go1),
        .go2 (go2)
    );

    assign load = (st == S_IDLE) && start;
    assign adv  = (st == S_WREL) && mem_ack;

    txd_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .base     (ring_base),
        .advance  (adv),
        .chained  (ctl.chained),
        .end_ring (ctl.end_ring),
        .link     (w3[AW-1:0]),
        .cur      (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            idx  <= '0;
            w0   <= '0;
            w1   <= '0;
            w2   <= '0;
            w3   <= '0;
            ts_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st  <= S_RD;
                    idx <= '0;
                end
                S_RD: if (mem_ack) begin
                    case (idx)
                        2'd0: w0 <= mem_rdata;
                        2'd1: w1 <= mem_rdata;
                        2'd2: w2 <= mem_rdata;
                        default: w3 <= mem_rdata;
                    endcase
                    idx <= idx + 2'd1;
                    if (idx == 2'd0 && !mem_rdata[W0_OWN]) begin
                        st  <= S_SUSP;
                        idx <= '0;
                    end else if (idx == 2'd3) begin
                        st <= S_CMD1;
                    end
                end
                S_SUSP: if (poll) begin
                    st  <= S_RD;
                    idx <= '0;
                end
                S_CMD1: if (!go1 || cmd_ready) st <= S_CMD2;
                S_CMD2: if (!go2 || cmd_ready) st <= ctl.last_seg ? S_WAIT : S_WREL;
                S_WAIT: if (frame_done) begin
                    ts_q <= ts_in;
                    st   <= ctl.ts_en ? S_WTSL : S_WREL;
                end
                S_WTSL: if (mem_ack) st <= S_WTSH;
                S_WTSH: if (mem_ack) st <= S_WREL;
                S_WREL: if (mem_ack) begin
                    st  <= S_RD;
                    idx <= '0;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        case (st)
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'({idx, 2'b00});
            end
            S_WTSL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur + OFF_W2;
                mem_wdata = ts_q[HALF-1:0];
            end
            S_WTSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur + OFF_W3;
                mem_wdata = ts_q[TSW-1:HALF];
            end
            S_WREL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = w0;
                mem_wdata[W0_OWN] = 1'b0;
            end
            default: ;
        endcase
    end

    assign cmd_valid = ((st == S_CMD1) && go1) || ((st == S_CMD2) && go2);
    assign cmd_addr  = (st == S_CMD1) ? w2[AW-1:0] : w3[AW-1:0];
    assign cmd_len   = (st == S_CMD1) ? ctl.len1 : ctl.len2;
    assign suspended = (st == S_SUSP);

    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

    assert_no_zero_len_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len != '0));

    assert_susp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (!cmd_valid && !mem_req));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    assert_release_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr == cur) |-> !mem_wdata[W0_OWN]);

    assert_no_cmd_unowned_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ctl.owned);
endmodule

// File: tb/txdesc_walker_bench.sv
`timescale 1ns/1ps
module txdesc_walker_bench;
    localparam int AW = 32;
    localparam logic [31:0] BASE  = 32'h100;
    localparam logic [31:0] LINK  = 32'h180;
    localparam int NROW = 6;
    // {chain, eor, tsen, last, rsv[2:0], len1[12:0], len2[12:0]}
    localparam logic [32:0] VEC [NROW] = '{
        {1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 13'd100,  13'd200},
        {1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 13'd0,    13'd64},
        {1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 13'd50,   13'd999},
        {1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 13'd0,    13'd77},
        {1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 13'd12,   13'd0},
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 13'd8191, 13'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, poll = 1'b0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic cmd_valid, cmd_ready = 1'b1;
    logic [AW-1:0] cmd_addr;
    logic [12:0] cmd_len;
    logic frame_done;
    logic [63:0] ts_in = '0;
    logic suspended;

    logic [31:0] mem [256];
    logic tb_we = 1'b0, clr = 1'b0;
    logic [7:0] tb_wa = '0;
    logic [31:0] tb_wd = '0;
    logic [31:0] cmd_a_log [16];
    logic [12:0] cmd_l_log [16];
    logic [31:0] wr_log [16];
    int n_cmd = 0, n_wr = 0;
    logic [31:0] last_rd = '0;
    logic [2:0] fd_cnt = '0;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    txdesc_walker u_txdesc_walker (
        .clk(clk), .rst(rst), .start(start), .poll(poll), .ring_base(BASE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .frame_done(frame_done), .ts_in(ts_in), .suspended(suspended)
    );

    assign frame_done = (fd_cnt == 3'd7);

    always @(posedge clk) begin
        fd_cnt  <= fd_cnt + 3'd1;
        mem_ack <= 1'b0;
        if (tb_we) mem[tb_wa] <= tb_wd;
        if (clr) begin
            n_cmd <= 0;
            n_wr  <= 0;
        end else begin
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    wr_log[n_wr[3:0]] <= mem_addr;
                    n_wr <= n_wr + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                    last_rd   <= mem_addr;
                end
            end
            if (cmd_valid && cmd_ready) begin
                cmd_a_log[n_cmd[3:0]] <= cmd_addr;
                cmd_l_log[n_cmd[3:0]] <= cmd_len;
                n_cmd <= n_cmd + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = a[9:2]; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr = 1'b1;
        for (int i = 0; i < 256; i++) poke(i * 4, 32'h0);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_susp(input string req);
        int t = 0;
        while (!suspended && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(suspended, req, {63'd0, suspended}, 64'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        chk(!mem_req && !cmd_valid && !suspended, "R1 reset idle",
            {61'd0, mem_req, cmd_valid, suspended}, 64'd0);
        repeat (5) @(negedge clk);
        chk(!mem_req, "R1 no activity before start", {63'd0, mem_req}, 64'd0);

        for (int r = 0; r < NROW; r++) begin
            logic ch, eor, tse, ls;
            logic [2:0] rsv;
            logic [12:0] l1, l2;
            logic [31:0] w0, w1, w2, w3, nxt;
            logic [63:0] ts;
            int ec;
            logic [31:0] ea [2];
            logic [12:0] el [2];
            logic tsw;
            {ch, eor, tse, ls, rsv, l1, l2} = VEC[r];
            w0 = (32'd1 << 31) | ({31'd0, ls} << 29) | (32'd1 << 28) | ({31'd0, tse} << 25)
               | ({31'd0, eor} << 21) | ({31'd0, ch} << 20) | 32'h5;
            w1 = ({19'd0, l2} << 16) | ({29'd0, rsv} << 13) | {19'd0, l1} | 32'hE000_0000;
            w2 = 32'h1003 + r;
            w3 = ch ? LINK : (32'h2005 + r);
            ts = {32'hA000_0000 + r, 32'h5000_0000 + r};
            nxt = ch ? LINK : (eor ? BASE : BASE + 32'd16);
            tsw = tse && ls;
            ec = 0;
            if (l1 != 0) begin ea[ec] = w2; el[ec] = l1; ec++; end
            if (!ch && l2 != 0) begin ea[ec] = w3; el[ec] = l2; ec++; end

            do_reset();
            clear_all();
            poke(BASE, w0); poke(BASE + 4, w1); poke(BASE + 8, w2); poke(BASE + 12, w3);
            ts_in = ts;
            pulse_start();
            if (r == 0) begin
                // R11, R12: first access is a read of word 0 at the base
                chk(mem_req && !mem_we && mem_addr == BASE, "R11 R12 first read at base",
                    {32'd0, mem_addr}, {32'd0, BASE});
            end
            wait_susp("R9 suspend on next descriptor");
            // R2 R3 R4 R5 R6: command list
            chk(n_cmd == ec, "R3 R4 R5 command count", 64'(n_cmd), 64'(ec));
            for (int k = 0; k < ec && k < n_cmd; k++) begin
                chk(cmd_a_log[k] == ea[k], "R6 command address", {32'd0, cmd_a_log[k]}, {32'd0, ea[k]});
                chk(cmd_l_log[k] == el[k], "R2 command length", {51'd0, cmd_l_log[k]}, {51'd0, el[k]});
            end
            // R5 R4: next descriptor address
            chk(last_rd == nxt, "R4 R5 next descriptor", {32'd0, last_rd}, {32'd0, nxt});
            // R7 R8: write order
            chk(n_wr == (tsw ? 3 : 1), "R7 write count", 64'(n_wr), tsw ? 64'd3 : 64'd1);
            if (tsw && n_wr == 3) begin
                chk(wr_log[0] == BASE + 8 && wr_log[1] == BASE + 12, "R8 timestamp writes first",
                    {wr_log[0], wr_log[1]}, {BASE + 32'd8, BASE + 32'd12});
                chk(wr_log[2] == BASE, "R8 R11 release last", {32'd0, wr_log[2]}, {32'd0, BASE});
            end else if (n_wr == 1) begin
                chk(wr_log[0] == BASE, "R8 R11 release only", {32'd0, wr_log[0]}, {32'd0, BASE});
            end
            chk(mem[BASE[9:2]] == (w0 & 32'h7FFF_FFFF), "R8 released word 0",
                {32'd0, mem[BASE[9:2]]}, {32'd0, w0 & 32'h7FFF_FFFF});
            chk({mem[BASE[9:2] + 3], mem[BASE[9:2] + 2]} == (tsw ? ts : {w3, w2}), "R7 words 2 and 3",
                {mem[BASE[9:2] + 3], mem[BASE[9:2] + 2]}, tsw ? ts : {w3, w2});
        end

        // R9 R10: poll resume with command backpressure
        do_reset();
        clear_all();
        poke(BASE, 32'h8000_0000);
        poke(BASE + 4, 32'd16);
        poke(BASE + 8, 32'h0000_7001);
        pulse_start();
        wait_susp("R9 suspend at second descriptor");
        chk(n_cmd == 1 && n_wr == 1, "R9 nothing done for unowned",
            64'(n_wr), 64'd1);
        chk(last_rd == BASE + 16, "R9 R5 stopped address", {32'd0, last_rd}, {32'd0, BASE + 32'd16});
        poke(BASE + 16, 32'h8000_0000);
        poke(BASE + 20, 32'd32);
        poke(BASE + 24, 32'h0000_3000);
        repeat (10) @(negedge clk);
        chk(suspended && n_cmd == 1, "R9 stays suspended without poll", 64'(n_cmd), 64'd1);
        cmd_ready = 1'b0;
        @(negedge clk);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        repeat (20) @(negedge clk);
        chk(cmd_valid && cmd_addr == 32'h3000 && cmd_len == 13'd32, "R10 command held",
            {cmd_valid, 19'd0, cmd_len, cmd_addr}, {1'b1, 19'd0, 13'd32, 32'h3000});
        chk(n_cmd == 1, "R10 no accept while not ready", 64'(n_cmd), 64'd1);
        cmd_ready = 1'b1;
        @(negedge clk);
        wait_susp("R9 suspend after resume");
        chk(n_cmd == 2 && cmd_a_log[1] == 32'h3000, "R9 resumed command",
            {32'd0, cmd_a_log[1]}, 64'h3000);
        chk(last_rd == BASE + 32, "R5 ring step after resume", {32'd0, last_rd}, {32'd0, BASE + 32'd32});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule